// File: doc/BRIEF.md
# Key-Sense and Wakeup Interrupt Combiner

This block gathers sixteen active-low key-sense inputs, eight active-low wakeup inputs and two dedicated active-low interrupt pins into two shared interrupt channels. Channel A (the "IRQ6" line) collects key inputs 7..0 and its dedicated pin. Channel B (the "IRQ7" line) collects key inputs 15..8, all wakeup inputs and its own dedicated pin. Every key and wakeup input has a mask bit. Each channel has a sense mode, either low-level or falling-edge, a request flag and an enable bit. The request output of a channel is its flag gated by that channel's enable.

Every pin first passes through a two-flop synchronizer. Each channel then forms one active-low combined line from its unmasked sources. A per-channel state machine turns that line into the flag. The machine has three states: `ST_IDLE` (flag clear), `ST_LEVEL` (flag tracking a low line in level mode) and `ST_LATCH` (flag captured by a falling edge). Its transitions are:
- *level-assert*: `ST_IDLE`/`ST_LEVEL` to `ST_LEVEL` while the line is low in level mode.
- *level-release*: `ST_LEVEL` to `ST_IDLE` when the line is high, or when the mode is edge and no edge is seen.
- *edge-capture*: `ST_IDLE`/`ST_LEVEL` to `ST_LATCH` on a falling edge in edge mode.
- *hold*: `ST_LATCH` to `ST_LATCH`.
- *clear*: `ST_LATCH` to `ST_IDLE` when the clear strobe is high and no new falling edge arrives in that cycle.

Software configures the block through a small byte-wide register port and clears captured flags with a two-bit strobe.

Top module: `kwu_irq_merge`

## Requirements
- R1: After reset:
  - addresses 0, 1 and 2 read 0xFF (all sources masked);
  - address 3 reads 0x00 (both channels disabled, level mode);
  - both flags are clear, so enabling a channel with idle inputs leaves its request low.
- R2: The register map is:
  - address 0 holds key mask bits 7..0 and address 1 holds key mask bits 15..8;
  - address 2 holds wakeup mask bits 7..0;
  - address 3 is control: bit0 enables channel A, bit1 enables channel B, bit2 selects falling-edge mode for channel A, bit3 selects falling-edge mode for channel B (0 means level). Bits 7..4 of address 3 read 0.
  - Writes with `cfg_we` high take effect at the clock edge. Reads are combinational from `cfg_addr`, and unmapped addresses read 0.
- R3: A mask bit of 0 lets its source drive the channel. A source whose mask bit is 1 never raises the channel's flag.
- R4: Key inputs 7..0 drive only channel A. Key inputs 15..8 and wakeup inputs 7..0 drive only channel B.
- R5: The dedicated channel B pin contributes only when key mask bits 15..8 and wakeup mask bits 7..0 are all 1. If any of those bits is 0, the pin is ignored.
- R6: The dedicated channel A pin shares key mask bit 6: it contributes only while that bit is 0.
- R7: In level mode the flag follows the combined line: set while the line is low, clear while it is high. The clear strobe has no effect in this mode.
- R8: In falling-edge mode, a high-to-low transition of the combined line sets the flag, and the flag then holds until the channel's clear strobe bit is pulsed (`flag_clr` bit0 for channel A, bit1 for channel B). A falling edge in the same cycle as the clear leaves the flag set.
- R9: A flag is set by its sense condition whether or not the channel is enabled. The request output equals the flag ANDed with the enable, so enabling a channel later reveals a flag captured while it was disabled.
- R10: A pin change reaches the request output on the third rising clock edge after it. At the second edge the output still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 16 | Key-sense inputs, active low |
| wake_n | input | 8 | Wakeup-event inputs, active low |
| irq6_n | input | 1 | Dedicated channel A pin, active low |
| irq7_n | input | 1 | Dedicated channel B pin, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| flag_clr | input | 2 | Flag clear strobe, bit0 channel A, bit1 channel B |
| req6 | output | 1 | Channel A interrupt request |
| req7 | output | 1 | Channel B interrupt request |

## Verification
The bench targets the following corner cases:
- **Gating of the dedicated channel B pin.** The pin is tried with all sixteen sharing masks set and then with one wakeup mask cleared. A design that ignored the blocking rule would raise a request in the second case.
- **Captured flag.** A flag latched while the channel is disabled must appear when the channel is enabled. A clear that lands in the same cycle as a new falling edge must not win; a design that gave the clear priority would silently drop that interrupt.
- **Level-mode clear.** The clear strobe is pulsed while a level is held low, and the flag must stay set.
- **Synchronizer latency.** Latency is checked both at two edges and at three edges, so a missing or extra synchronizer stage shows up.

// File: rtl/kwu_pkg.sv
package kwu_pkg;

    // per-channel flag state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEVEL = 2'd1,
        ST_LATCH = 2'd2
    } chan_st_e;

    // channel indices inside two-bit vectors
    localparam int CH_A = 0;
    localparam int CH_B = 1;
    localparam int NUM_CH = 2;

    // control register bit positions
    localparam int CTRL_EN_A   = 0;
    localparam int CTRL_EN_B   = 1;
    localparam int CTRL_EDGE_A = 2;
    localparam int CTRL_EDGE_B = 3;
    localparam int CTRL_BITS   = 4;

endpackage

// File: rtl/kwu_sync.sv
module kwu_sync #(
    parameter int W      = 26,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '1;
            end
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/kwu_regs.sv
module kwu_regs
    import kwu_pkg::*;
#(
    parameter int NUM_KEY  = 16,
    parameter int NUM_WAKE = 8,
    parameter int DW       = 8,
    parameter int AW       = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [NUM_KEY-1:0]  key_mask,
    output logic [NUM_WAKE-1:0] wake_mask,
    output logic [NUM_CH-1:0]   en,
    output logic [NUM_CH-1:0]   edge_mode
);

    localparam int KEY_REGS  = NUM_KEY / DW;
    localparam int WAKE_REGS = NUM_WAKE / DW;
    localparam int MASK_REGS = KEY_REGS + WAKE_REGS;
    localparam logic [AW-1:0] CTRL_ADDR = AW'(MASK_REGS);

    logic [DW-1:0]        bank [MASK_REGS];
    logic [CTRL_BITS-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MASK_REGS; i++) begin
                bank[i] <= '1;
            end
            ctrl_q <= '0;
        end else if (we) begin
            for (int i = 0; i < MASK_REGS; i++) begin
                if (addr == AW'(i)) begin
                    bank[i] <= wdata;
                end
            end
            if (addr == CTRL_ADDR) begin
                ctrl_q <= wdata[CTRL_BITS-1:0];
            end
        end
    end

    genvar gk;
    generate
        for (gk = 0; gk < KEY_REGS; gk++) begin : g_key
            assign key_mask[gk*DW +: DW] = bank[gk];
        end
        for (gk = 0; gk < WAKE_REGS; gk++) begin : g_wake
            assign wake_mask[gk*DW +: DW] = bank[KEY_REGS + gk];
        end
    endgenerate

    assign en[CH_A]        = ctrl_q[CTRL_EN_A];
    assign en[CH_B]        = ctrl_q[CTRL_EN_B];
    assign edge_mode[CH_A] = ctrl_q[CTRL_EDGE_A];
    assign edge_mode[CH_B] = ctrl_q[CTRL_EDGE_B];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < MASK_REGS; i++) begin
            if (addr == AW'(i)) begin
                rdata = bank[i];
            end
        end
        if (addr == CTRL_ADDR) begin
            rdata = DW'(ctrl_q);
        end
    end

endmodule

// File: rtl/kwu_line_merge.sv
module kwu_line_merge
    import kwu_pkg::*;
#(
    parameter int NUM_KEY  = 16,
    parameter int NUM_WAKE = 8,
    parameter int PIN_A_KEY = 6
) (
    input  logic [NUM_KEY-1:0]  key_s,
    input  logic [NUM_WAKE-1:0] wake_s,
    input  logic                pin_a_s,
    input  logic                pin_b_s,
    input  logic [NUM_KEY-1:0]  key_mask,
    input  logic [NUM_WAKE-1:0] wake_mask,
    output logic [NUM_CH-1:0]   line_n
);

    localparam int KEY_LO = NUM_KEY / 2;

    logic [KEY_LO-1:0]         lo_act;
    logic [NUM_KEY-KEY_LO-1:0] hi_act;
    logic [NUM_WAKE-1:0]       wk_act;
    logic                      pin_a_act;
    logic                      pin_b_act;
    logic                      b_all_masked;

    // a source is active when its pin is low and its mask bit is 0
    assign lo_act = ~key_s[KEY_LO-1:0] & ~key_mask[KEY_LO-1:0];
    assign hi_act = ~key_s[NUM_KEY-1:KEY_LO] & ~key_mask[NUM_KEY-1:KEY_LO];
    assign wk_act = ~wake_s & ~wake_mask;

    // channel A pin rides on the gate of its shared key position
    assign pin_a_act = ~pin_a_s & ~key_mask[PIN_A_KEY];

    // channel B pin is blocked unless every source sharing the line is masked
    assign b_all_masked = (&key_mask[NUM_KEY-1:KEY_LO]) & (&wake_mask);
    assign pin_b_act    = ~pin_b_s & b_all_masked;

    assign line_n[CH_A] = ~((|lo_act) | pin_a_act);
    assign line_n[CH_B] = ~((|hi_act) | (|wk_act) | pin_b_act);

endmodule

// File: rtl/kwu_chan_fsm.sv
module kwu_chan_fsm
    import kwu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    input  logic edge_mode,
    input  logic clr,
    output logic line_prev,
    output logic flag,
    output logic latched
);

    chan_st_e state_q;
    chan_st_e state_d;
    logic     fell;

    assign fell = line_prev & ~line_n;

    // state register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            line_prev <= 1'b1;
        end else begin
            state_q   <= state_d;
            line_prev <= line_n;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_LEVEL: begin
                if (edge_mode) begin
                    state_d = fell ? ST_LATCH : ST_IDLE;
                end else begin
                    state_d = line_n ? ST_IDLE : ST_LEVEL;
                end
            end
            ST_LATCH: begin
                // a fresh edge outranks the clear
                if (clr && !fell) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flag    = (state_q != ST_IDLE);
        latched = (state_q == ST_LATCH);
    end

endmodule

// File: rtl/kwu_irq_merge.sv
module kwu_irq_merge
    import kwu_pkg::*;
#(
    parameter int NUM_KEY     = 16,
    parameter int NUM_WAKE    = 8,
    parameter int DW          = 8,
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2,
    parameter int PIN_A_KEY   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEY-1:0]  key_n,
    input  logic [NUM_WAKE-1:0] wake_n,
    input  logic                irq6_n,
    input  logic                irq7_n,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [DW-1:0]       cfg_rdata,
    input  logic [NUM_CH-1:0]   flag_clr,
    output logic                req6,
    output logic                req7
);

    localparam int SYNC_W = NUM_KEY + NUM_WAKE + 2;

    logic [SYNC_W-1:0]   raw_vec;
    logic [SYNC_W-1:0]   sync_vec;
    logic [NUM_KEY-1:0]  key_s;
    logic [NUM_WAKE-1:0] wake_s;
    logic                pin_a_s;
    logic                pin_b_s;
    logic [NUM_KEY-1:0]  key_mask;
    logic [NUM_WAKE-1:0] wake_mask;
    logic [NUM_CH-1:0]   en_q;
    logic [NUM_CH-1:0]   edge_mode;
    logic [NUM_CH-1:0]   line_n;
    logic [NUM_CH-1:0]   line_q;
    logic [NUM_CH-1:0]   flag;
    logic [NUM_CH-1:0]   latched;
    logic [NUM_CH-1:0]   req_vec;

    assign raw_vec = {irq7_n, irq6_n, wake_n, key_n};

    kwu_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (sync_vec)
    );

    assign {pin_b_s, pin_a_s, wake_s, key_s} = sync_vec;

    kwu_regs #(
        .NUM_KEY  (NUM_KEY),
        .NUM_WAKE (NUM_WAKE),
        .DW       (DW),
        .AW       (AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .key_mask  (key_mask),
        .wake_mask (wake_mask),
        .en        (en_q),
        .edge_mode (edge_mode)
    );

    kwu_line_merge #(
        .NUM_KEY   (NUM_KEY),
        .NUM_WAKE  (NUM_WAKE),
        .PIN_A_KEY (PIN_A_KEY)
    ) u_merge (
        .key_s     (key_s),
        .wake_s    (wake_s),
        .pin_a_s   (pin_a_s),
        .pin_b_s   (pin_b_s),
        .key_mask  (key_mask),
        .wake_mask (wake_mask),
        .line_n    (line_n)
    );

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            kwu_chan_fsm u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .line_n    (line_n[gc]),
                .edge_mode (edge_mode[gc]),
                .clr       (flag_clr[gc]),
                .line_prev (line_q[gc]),
                .flag      (flag[gc]),
                .latched   (latched[gc])
            );
            assign req_vec[gc] = flag[gc] & en_q[gc];
        end
    endgenerate

    assign req6 = req_vec[CH_A];
    assign req7 = req_vec[CH_B];

endmodule

// File: rtl/kwu_irq_merge_chk.sv
module kwu_irq_merge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_n,
    input logic [1:0] line_q,
    input logic [1:0] flag,
    input logic [1:0] latched,
    input logic [1:0] edge_mode,
    input logic [1:0] en,
    input logic [1:0] clr,
    input logic [1:0] req
);

    genvar gc;
    generate
        for (gc = 0; gc < 2; gc++) begin : g_chk
            // R8: a captured flag survives every cycle without a clear
            p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (latched[gc] && !clr[gc]) |=> (latched[gc] && flag[gc]));

            // R8: clear without a coincident fall empties the flag
            p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (latched[gc] && clr[gc] && !(line_q[gc] && !line_n[gc])) |=> !flag[gc]);

            // R9: an edge in edge mode sets the flag whatever the enable
            p_edge_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[gc] && line_q[gc] && !line_n[gc]) |=> flag[gc]);

            // R7: in level mode the flag tracks the previous line value
            p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!edge_mode[gc] && !latched[gc]) |=> (flag[gc] == !$past(line_n[gc])));

            // R9: a disabled channel never requests
            p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !en[gc] |-> !req[gc]);
        end
    endgenerate

endmodule

bind kwu_irq_merge kwu_irq_merge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_n    (line_n),
    .line_q    (line_q),
    .flag      (flag),
    .latched   (latched),
    .edge_mode (edge_mode),
    .en        (en_q),
    .clr       (flag_clr),
    .req       (req_vec)
);

// File: tb/sim_kwu_irq_merge.sv
`timescale 1ns/1ps
module sim_kwu_irq_merge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] key_n = '1;
    logic [7:0]  wake_n = '1;
    logic        irq6_n = 1'b1;
    logic        irq7_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [1:0]  flag_clr = '0;
    logic        req6;
    logic        req7;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int    due;
        logic  e6;
        logic  e7;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kwu_irq_merge u0 (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .wake_n(wake_n),
        .irq6_n(irq6_n), .irq7_n(irq7_n), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .flag_clr(flag_clr), .req6(req6), .req7(req7)
    );

    // monitor: pops due items and compares them with the outputs
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (req6 !== it.e6 || req7 !== it.e7) begin
                errors++;
                $display("FAIL %s req6/req7 actual %b%b expected %b%b", it.tag, req6, req7, it.e6, it.e7);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expq(input int dly, input logic e6, input logic e7, input string tag);
        exp_t it;
        it.due = cyc + dly;
        it.e6 = e6;
        it.e7 = e7;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== e) begin
            errors++;
            $display("FAIL %s rdata[%0d] actual %h expected %h", tag, a, cfg_rdata, e);
        end
    endtask

    task automatic chk_req(input logic e6, input logic e7, input string tag);
        #1;
        checks++;
        if (req6 !== e6 || req7 !== e7) begin
            errors++;
            $display("FAIL %s req6/req7 actual %b%b expected %b%b", tag, req6, req7, e6, e7);
        end
    endtask

    task automatic pulse_clr(input logic [1:0] b);
        flag_clr = b;
        @(negedge clk);
        flag_clr = '0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state, R2 map
        chk_rd(3'd0, 8'hFF, "R1");
        chk_rd(3'd1, 8'hFF, "R1");
        chk_rd(3'd2, 8'hFF, "R1");
        chk_rd(3'd3, 8'h00, "R1");
        chk_rd(3'd5, 8'h00, "R2");
        chk_req(1'b0, 1'b0, "R1");
        step(1);
        wr(3'd3, 8'hF3);
        chk_rd(3'd3, 8'h03, "R2");
        chk_req(1'b0, 1'b0, "R1");
        wr(3'd0, 8'hFE);
        chk_rd(3'd0, 8'hFE, "R2");

        // R7 level mode, R10 latency, R4 routing
        key_n[0] = 1'b0;
        expq(2, 1'b0, 1'b0, "R10");
        expq(3, 1'b1, 1'b0, "R7");
        step(3);
        key_n[0] = 1'b1;
        expq(2, 1'b1, 1'b0, "R10");
        expq(3, 1'b0, 1'b0, "R7");
        step(4);

        // R3 masked source
        key_n[1] = 1'b0;
        expq(4, 1'b0, 1'b0, "R3");
        step(5);
        key_n[1] = 1'b1;
        step(3);

        // R4 channel B sources
        wr(3'd1, 8'h7F);
        key_n[15] = 1'b0;
        expq(3, 1'b0, 1'b1, "R4");
        step(3);
        key_n[15] = 1'b1;
        expq(3, 1'b0, 1'b0, "R4");
        step(3);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFB);
        wake_n[2] = 1'b0;
        expq(3, 1'b0, 1'b1, "R4");
        step(3);
        wake_n[2] = 1'b1;
        step(3);
        wr(3'd2, 8'hFF);

        // R5 dedicated channel B pin
        irq7_n = 1'b0;
        expq(3, 1'b0, 1'b1, "R5");
        step(3);
        irq7_n = 1'b1;
        expq(3, 1'b0, 1'b0, "R5");
        step(3);
        wr(3'd2, 8'hFE);
        irq7_n = 1'b0;
        expq(4, 1'b0, 1'b0, "R5");
        step(5);
        irq7_n = 1'b1;
        step(3);
        wr(3'd2, 8'hFF);

        // R6 dedicated channel A pin
        irq6_n = 1'b0;
        expq(4, 1'b0, 1'b0, "R6");
        step(5);
        irq6_n = 1'b1;
        step(3);
        wr(3'd0, 8'hBF);
        irq6_n = 1'b0;
        expq(3, 1'b1, 1'b0, "R6");
        step(3);
        irq6_n = 1'b1;
        expq(3, 1'b0, 1'b0, "R6");
        step(3);

        // R8 edge mode sticky and clear
        wr(3'd0, 8'hFE);
        wr(3'd3, 8'h07);
        key_n[0] = 1'b0;
        expq(3, 1'b1, 1'b0, "R8");
        step(3);
        key_n[0] = 1'b1;
        expq(4, 1'b1, 1'b0, "R8");
        step(5);
        pulse_clr(2'b01);
        chk_req(1'b0, 1'b0, "R8");

        // R9 capture while disabled
        wr(3'd3, 8'h06);
        key_n[0] = 1'b0;
        step(3);
        key_n[0] = 1'b1;
        expq(3, 1'b0, 1'b0, "R9");
        step(4);
        wr(3'd3, 8'h07);
        chk_req(1'b1, 1'b0, "R9");

        // R8 fall coinciding with clear keeps flag
        key_n[0] = 1'b0;
        step(2);
        flag_clr = 2'b01;
        step(1);
        flag_clr = 2'b00;
        chk_req(1'b1, 1'b0, "R8");
        pulse_clr(2'b01);
        chk_req(1'b0, 1'b0, "R8");
        key_n[0] = 1'b1;
        step(3);

        // R7 clear ignored in level mode
        wr(3'd3, 8'h03);
        key_n[0] = 1'b0;
        expq(3, 1'b1, 1'b0, "R7");
        step(3);
        pulse_clr(2'b11);
        chk_req(1'b1, 1'b0, "R7");
        key_n[0] = 1'b1;
        expq(3, 1'b0, 1'b0, "R7");
        step(3);

        // R8 channel B edge with its own clear bit
        wr(3'd3, 8'h0B);
        wr(3'd2, 8'hFE);
        wake_n[0] = 1'b0;
        expq(3, 1'b0, 1'b1, "R8");
        step(3);
        wake_n[0] = 1'b1;
        step(3);
        pulse_clr(2'b01);
        chk_req(1'b0, 1'b1, "R8");
        pulse_clr(2'b10);
        chk_req(1'b0, 1'b0, "R8");

        while (sb.size() > 0) @(negedge clk);
        step(1);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule